// File: doc/BRIEF.md
# Byte-Parallel CRC-8 Generator

This block accumulates an 8-bit cyclic redundancy check over a stream of bytes and takes one whole byte on each clock. The generator polynomial is x^8 + x^2 + x + 1. The result is identical to a one-bit-per-clock shift register that receives the same bits, most significant bit of each byte first. The eight serial steps are unrolled into a chain of XOR cells, so a byte is folded into the running remainder in a single cycle.

An upstream framer pulses reset at the start of a message. It then raises the enable and the byte-valid strobe together for every byte it presents. The finished check value can be read on `crc_out` at any time. The output is bit-reversed and complemented relative to the internal remainder register, which is the order and polarity that the link expects.

Top module: `crc8_byte_gen`

## Requirements
- R1: A synchronous reset loads the internal remainder with all ones, so `crc_out` reads 0x00 in the cycle after the reset edge.
- R2: Reset takes priority over enable and strobe: with `rst` high and both `en` and `byte_vld` high, `crc_out` still reads 0x00 after the edge.
- R3: With `en` low, the remainder holds and `crc_out` does not change, whatever `byte_vld` and `data_in` are.
- R4: With `en` high and `byte_vld` low, the remainder holds and `crc_out` does not change.
- R5: When `en` and `byte_vld` are high at an edge, the remainder advances by eight serial steps. Bit 7 of `data_in` is applied first. In each step, feedback f = data bit XOR remainder bit 7; the new bit 0 = f, bit 1 = old bit 0 XOR f, bit 2 = old bit 1 XOR f, and bits 7..3 take old bits 6..2. From reset, the byte 0x00 gives `crc_out` = 0x30.
- R6: Consecutive strobed bytes chain: each byte starts from the remainder that the previous byte left, with or without idle cycles in between.
- R7: `crc_out[i]` equals the complement of remainder bit 7-i. It is combinational from the register, so it is valid in the cycle after the edge that accepted the last byte.
- R8: All-zero and all-ones bytes, and long runs of either, follow the same serial rule as any other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, loads remainder with all ones |
| en | input | 1 | Enable; must be high for a byte to be accepted |
| byte_vld | input | 1 | Byte-valid strobe qualifying `data_in` |
| data_in | input | 8 | Byte to fold in, bit 7 applied first |
| crc_out | output | 8 | Bit-reversed, complemented remainder |

## Verification
Every result is due exactly one clock after its stimulus. A byte accepted at a rising edge, or a reset taken there, shows on `crc_out` before the following falling edge, because only the remainder register lies on the path. The bench drives inputs at falling edges and compares `crc_out` at the next falling edge against a bit-serial model that is advanced only when reset, or enable together with the strobe, was high at the edge between. Held cycles are compared the same way, so an output that moves when it should not is caught in that same cycle.

// File: rtl/crc8_pkg.sv
package crc8_pkg;

    localparam int unsigned CRC_W  = 8;
    localparam int unsigned BYTE_W = 8;
    localparam logic [CRC_W-1:0] GEN_POLY  = 8'h07;
    localparam logic [CRC_W-1:0] SEED_VAL  = 8'hFF;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  take;
        byte_t data;
    } feed_t;

    // One serial division step, written as a loop over taps.
    function automatic crc_t serial_step(input crc_t cur, input logic din);
        crc_t nx;
        logic fb;
        fb = din ^ cur[CRC_W-1];
        nx = '0;
        for (int i = 0; i < int'(CRC_W); i++) begin
            if (i == 0) nx[i] = fb;
            else        nx[i] = cur[i-1] ^ (GEN_POLY[i] & fb);
        end
        return nx;
    endfunction

    // Whole byte, MSB first, through the serial step.
    function automatic crc_t byte_ref(input crc_t cur, input byte_t b);
        crc_t acc;
        acc = cur;
        for (int k = int'(BYTE_W) - 1; k >= 0; k--) begin
            acc = serial_step(acc, b[k]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/crc8_step_cell.sv
module crc8_step_cell #(
    parameter int unsigned       W    = crc8_pkg::CRC_W,
    parameter logic [W-1:0]      POLY = crc8_pkg::GEN_POLY
) (
    input  logic [W-1:0] cur,
    input  logic         din,
    output logic [W-1:0] nxt
);
    logic fb;
    assign fb = din ^ cur[W-1];

    for (genvar i = 0; i < int'(W); i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign nxt[i] = fb;
        end else if (POLY[i]) begin : g_tap
            assign nxt[i] = cur[i-1] ^ fb;
        end else begin : g_shift
            assign nxt[i] = cur[i-1];
        end
    end
endmodule

// File: rtl/crc8_unroll.sv
module crc8_unroll #(
    parameter int unsigned  W    = crc8_pkg::CRC_W,
    parameter int unsigned  DW   = crc8_pkg::BYTE_W,
    parameter logic [W-1:0] POLY = crc8_pkg::GEN_POLY
) (
    input  logic [W-1:0]  cur,
    input  logic [DW-1:0] data,
    output logic [W-1:0]  nxt
);
    localparam int unsigned STAGES = DW;

    logic [W-1:0] chain [0:STAGES];

    assign chain[0] = cur;

    for (genvar k = 0; k < int'(STAGES); k++) begin : g_stage
        crc8_step_cell #(
            .W    (W),
            .POLY (POLY)
        ) u_cell (
            .cur (chain[k]),
            .din (data[DW-1-k]),
            .nxt (chain[k+1])
        );
    end

    assign nxt = chain[STAGES];
endmodule

// File: rtl/crc8_state.sv
module crc8_state #(
    parameter int unsigned  W    = crc8_pkg::CRC_W,
    parameter logic [W-1:0] SEED = crc8_pkg::SEED_VAL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= SEED;
        else if (load) q <= nxt;
    end

    // R1: reset edge leaves the seed in the register
    a_r1_seed_after_reset: assert property (@(posedge clk)
        rst |=> (q == SEED));

    // R3/R4: without a load the register keeps its value
    a_r3_hold_without_load: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/crc8_out_map.sv
module crc8_out_map #(
    parameter int unsigned W = crc8_pkg::CRC_W
) (
    input  logic [W-1:0] q,
    output logic [W-1:0] crc
);
    for (genvar i = 0; i < int'(W); i++) begin : g_rev
        assign crc[i] = ~q[W-1-i];
    end
endmodule

// File: rtl/crc8_byte_gen.sv
module crc8_byte_gen
    import crc8_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        byte_vld,
    input  logic [7:0]  data_in,
    output logic [7:0]  crc_out
);
    feed_t feed;
    crc_t  rem_q;
    crc_t  rem_nxt;

    assign feed.take = en & byte_vld;
    assign feed.data = data_in;

    crc8_unroll #(
        .W    (CRC_W),
        .DW   (BYTE_W),
        .POLY (GEN_POLY)
    ) u_unroll (
        .cur  (rem_q),
        .data (feed.data),
        .nxt  (rem_nxt)
    );

    crc8_state #(
        .W    (CRC_W),
        .SEED (SEED_VAL)
    ) u_state (
        .clk  (clk),
        .rst  (rst),
        .load (feed.take),
        .nxt  (rem_nxt),
        .q    (rem_q)
    );

    crc8_out_map #(
        .W (CRC_W)
    ) u_out (
        .q   (rem_q),
        .crc (crc_out)
    );

    // R5: one accepted byte equals eight serial steps, MSB first
    a_r5_matches_serial: assert property (@(posedge clk) disable iff (rst)
        (en && byte_vld) |=> (rem_q == byte_ref($past(rem_q), $past(data_in))));

    // R2: reset wins over a simultaneous strobe
    a_r2_reset_wins: assert property (@(posedge clk)
        (rst && en && byte_vld) |=> (crc_out == '0));

    // R4: strobe low with enable high leaves the output still
    a_r4_strobe_gate: assert property (@(posedge clk) disable iff (rst)
        (en && !byte_vld) |=> $stable(crc_out));
endmodule

// File: tb/test_crc8_byte_gen.sv
module test_crc8_byte_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic       byte_vld;
    logic [7:0] data_in;
    logic [7:0] crc_out;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    logic [7:0]  model;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    crc8_byte_gen i_crc8_byte_gen (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .byte_vld (byte_vld),
        .data_in  (data_in),
        .crc_out  (crc_out)
    );

    // Independent bit-serial model of the requirement text (R5).
    function automatic logic [7:0] ser_byte(input logic [7:0] r, input logic [7:0] b);
        logic [7:0] s;
        logic f;
        s = r;
        for (int k = 7; k >= 0; k--) begin
            f = b[k] ^ s[7];
            s = {s[6:2], s[1] ^ f, s[0] ^ f, f};
        end
        return s;
    endfunction

    function automatic logic [7:0] view(input logic [7:0] r);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) o[i] = ~r[7-i];
        return o;
    endfunction

    // Vector table: {rst, en, byte_vld, data}
    localparam int NV = 24;
    localparam logic [10:0] VEC [0:NV-1] = '{
        {3'b100, 8'h00}, {3'b011, 8'h31}, {3'b011, 8'h32}, {3'b001, 8'hAA},
        {3'b011, 8'h33}, {3'b010, 8'h55}, {3'b011, 8'hFF}, {3'b000, 8'h12},
        {3'b011, 8'h00}, {3'b011, 8'h80}, {3'b111, 8'hC3}, {3'b011, 8'h01},
        {3'b011, 8'hFF}, {3'b011, 8'hFF}, {3'b011, 8'hFF}, {3'b001, 8'h7E},
        {3'b011, 8'h00}, {3'b011, 8'h00}, {3'b011, 8'h00}, {3'b010, 8'h00},
        {3'b011, 8'hA5}, {3'b011, 8'h5A}, {3'b100, 8'hEE}, {3'b011, 8'h3C}
    };

    task automatic check(input string req, input logic [7:0] exp);
        n_chk++;
        if (crc_out !== exp) begin
            n_fail++;
            $display("FAIL %s: crc_out=%02h expected=%02h", req, crc_out, exp);
        end
    endtask

    // Drive at negedge, edge, compare at the following negedge.
    task automatic step(input logic r, input logic e, input logic s,
                        input logic [7:0] d, input string req);
        rst = r; en = e; byte_vld = s; data_in = d;
        @(posedge clk);
        if (r)           model = 8'hFF;
        else if (e && s) model = ser_byte(model, d);
        @(negedge clk);
        check(req, view(model));
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; byte_vld = 1'b0; data_in = '0;
        model = 8'hFF;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", 8'h00);

        // Vector walk (R3, R4, R5, R6, R7, R2 inside the table)
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:0], "R6 vector");
        end

        // R5 literal: one zero byte from reset gives 0x30
        step(1'b1, 1'b0, 1'b0, 8'h00, "R1");
        step(1'b0, 1'b1, 1'b1, 8'h00, "R5");
        check("R5 literal", 8'h30);

        // R2: reset with enable and strobe high
        step(1'b1, 1'b1, 1'b1, 8'hA5, "R2");
        check("R2 literal", 8'h00);

        // R3: enable low, strobe toggling, data moving
        step(1'b0, 1'b1, 1'b1, 8'h9C, "R7");
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b0, k[0], 8'(k * 37 + 5), "R3");
        end

        // R4: enable high, strobe low
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b1, 1'b0, 8'(k * 91 + 3), "R4");
        end

        // R8: long runs of zeros and ones
        step(1'b1, 1'b0, 1'b0, 8'h00, "R1");
        for (int k = 0; k < 12; k++) step(1'b0, 1'b1, 1'b1, 8'h00, "R8 zeros");
        for (int k = 0; k < 12; k++) step(1'b0, 1'b1, 1'b1, 8'hFF, "R8 ones");

        // R5/R6: random bytes with random gaps
        for (int k = 0; k < 300; k++) begin
            logic [31:0] rv;
            rv = $urandom();
            step(rv[31:28] == 4'h0, rv[9] | rv[10], rv[11] | rv[12],
                 rv[7:0], "R5 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: crc_out=%02h expected=done", crc_out);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule